// File: doc/BRIEF.md
# Write Acknowledge Retiming Bridge

This block joins a fast CPU bus to a slower video and DRAM controller that runs from its own oscillator. The two sides share no clock. Their only handshake is a data strobe going toward the controller and an active-low transfer acknowledge coming back. The controller raises its acknowledge early, because it expects a slow processor. The bridge therefore brings that acknowledge into the CPU clock domain and lets it through only after a fixed, build-time number of CPU clocks. As a result, a fast CPU never ends a cycle sooner than the original slow processor would have.

Only write cycles cross the bridge, because reads of the mirrored region are served by a shadow RAM. CPU write data reaches the controller through a strobe-controlled hold stage. The stage is transparent while the strobe is low and freezes when the strobe rises. It keeps the value until the next write begins, so the controller can still take the data after the fast CPU has dropped it. Whenever the controller performs its own reads, the stage outputs float.

The delay count depends on the chosen CPU clock rate and CPU family. An access by a 4-clock-minimum processor is 8 half-clock phases. A 3-clock asynchronous access is 6 phases. Cycles can start on any CPU clock, with any number of idle clocks between them, including none.

Top module: `ack_delay_bridge`

## Requirements
- R1: While `rst` is high and on the first clock after it, `cpuAckN` and `ctrlDsN` are high and `ctrlData` is high impedance.
- R2: `ctrlDsN` is low exactly when `cpuDsN` is low and `cpuRdWrN` is 0 (a write). A read strobe (`cpuRdWrN` = 1) leaves it high.
- R3: For a write, the controller acknowledge passes through a two-flop synchronizer and an edge detector, then a counter of `ACK_DELAY` clocks. If `ctrlAckN` first falls with the write strobe already low and is sampled low on clock edge e0, then `cpuAckN` goes low right after edge e0 + 2 + `ACK_DELAY`.
- R4: `cpuAckN` never goes low during a read strobe or while the bus is idle, whatever `ctrlAckN` does.
- R5: After `cpuDsN` rises, `cpuAckN` is high again after the next clock edge. The following cycle starts its count fresh, and an acknowledge level left over from the previous cycle cannot start it early.
- R6: Once low, `cpuAckN` stays low for as long as the write strobe stays low.
- R7: While the write strobe is low and `ctrlRdActive` is 0, `ctrlData` equals `cpuDataIn` in the same cycle.
- R8: After the write strobe rises, `ctrlData` holds the last written value. Changes on `cpuDataIn` and read strobes do not disturb it until the next write strobe.
- R9: While `ctrlRdActive` is 1, `ctrlData` is high impedance. When it returns to 0, the held value reappears.
- R10: If the write strobe rises before the delay has expired, no acknowledge is issued for that cycle, and the next write shows the full latency of R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst | input | 1 | Synchronous active-high reset |
| cpuDsN | input | 1 | CPU data strobe, active low, synchronous to `clk` |
| cpuRdWrN | input | 1 | CPU direction: 1 = read, 0 = write |
| cpuDataIn | input | DATA_W | CPU write data |
| ctrlAckN | input | 1 | Controller acknowledge, active low, asynchronous |
| ctrlRdActive | input | 1 | High while the controller reads its own memory |
| cpuAckN | output | 1 | Retimed acknowledge to the CPU, active low |
| ctrlDsN | output | 1 | Strobe forwarded to the controller for writes only |
| ctrlData | output | DATA_W | Held write data toward the controller, tri-stated |

## Verification
Two events can land on the same clocks: the strobe release that ends one cycle, and the start of the next cycle. At that moment the synchronizer may still carry the previous cycle's low acknowledge. The bench provokes this by following a write with another write after only one strobe-high clock. It pulls `ctrlAckN` low again in the very cycle the new strobe falls, then checks that the new acknowledge arrives exactly `ACK_DELAY` + 3 sampling points later, neither early from the stale level nor late. Aborted cycles are mixed in the same way, with the strobe rising one clock before the count expires, to show that the early release wins.

// File: rtl/ack_bridge_pkg.sv
package ack_bridge_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_ACK  = 2'd2
  } seqState_t;

  typedef struct packed {
    logic capture;   // write strobe active: pass and record data
    logic rdBlock;   // controller reading: float the data outputs
  } dpStrobe_t;
endpackage

// File: rtl/ack_sync.sv
module ack_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic asyncN,
  output logic levelN,
  output logic prevN
);
  localparam int CHAIN_W = STAGES + 1;

  logic [CHAIN_W-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '1;
    else     chain <= {chain[CHAIN_W-2:0], asyncN};
  end

  assign levelN = chain[STAGES-1];
  assign prevN  = chain[STAGES];
endmodule

// File: rtl/bridge_ctrl.sv
module bridge_ctrl
  import ack_bridge_pkg::*;
#(
  parameter int ACK_DELAY = 4
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      cpuDsN,
  input  logic      cpuRdWrN,
  input  logic      ackLevelN,
  input  logic      ackPrevN,
  input  logic      ctrlRdActive,
  output logic      cpuAckN,
  output logic      ctrlDsN,
  output dpStrobe_t strobe
);
  localparam int CNT_W = $clog2(ACK_DELAY + 1);
  localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(ACK_DELAY);
  localparam logic [CNT_W-1:0] LAST_VAL = CNT_W'(1);

  seqState_t        state;
  logic [CNT_W-1:0] waitCnt;
  logic             wrActive;
  logic             ackFall;

  assign wrActive = !cpuDsN && !cpuRdWrN;
  assign ackFall  = !ackLevelN && ackPrevN;

  always_ff @(posedge clk) begin
    if (rst || !wrActive) begin
      state   <= ST_IDLE;
      waitCnt <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (ackFall) begin
          state   <= ST_WAIT;
          waitCnt <= LOAD_VAL;
        end
        ST_WAIT: begin
          waitCnt <= waitCnt - LAST_VAL;
          if (waitCnt == LAST_VAL) state <= ST_ACK;
        end
        ST_ACK:  state <= ST_ACK;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign cpuAckN        = (state != ST_ACK);
  assign ctrlDsN        = !wrActive;
  assign strobe.capture = wrActive;
  assign strobe.rdBlock = ctrlRdActive;
endmodule

// File: rtl/bridge_datapath.sv
module bridge_datapath
  import ack_bridge_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  dpStrobe_t         strobe,
  input  logic [DATA_W-1:0] cpuDataIn,
  output logic [DATA_W-1:0] ctrlData
);
  logic [DATA_W-1:0] holdReg;
  logic              holdValid;
  logic [DATA_W-1:0] driveVal;
  logic              driveEn;

  always_ff @(posedge clk) begin
    if (rst) begin
      holdReg   <= '0;
      holdValid <= 1'b0;
    end else if (strobe.capture) begin
      holdReg   <= cpuDataIn;
      holdValid <= 1'b1;
    end
  end

  assign driveVal = strobe.capture ? cpuDataIn : holdReg;
  assign driveEn  = (holdValid || strobe.capture) && !strobe.rdBlock && !rst;
  assign ctrlData = driveEn ? driveVal : {DATA_W{1'bz}};
endmodule

// File: rtl/ack_delay_bridge.sv
module ack_delay_bridge
  import ack_bridge_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int ACK_DELAY   = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpuDsN,
  input  logic              cpuRdWrN,
  input  logic [DATA_W-1:0] cpuDataIn,
  input  logic              ctrlAckN,
  input  logic              ctrlRdActive,
  output logic              cpuAckN,
  output logic              ctrlDsN,
  output logic [DATA_W-1:0] ctrlData
);
  logic      ackLevelN;
  logic      ackPrevN;
  dpStrobe_t strobe;

  ack_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .asyncN(ctrlAckN),
    .levelN(ackLevelN), .prevN(ackPrevN)
  );

  bridge_ctrl #(.ACK_DELAY(ACK_DELAY)) u_ctrl (
    .clk(clk), .rst(rst), .cpuDsN(cpuDsN), .cpuRdWrN(cpuRdWrN),
    .ackLevelN(ackLevelN), .ackPrevN(ackPrevN), .ctrlRdActive(ctrlRdActive),
    .cpuAckN(cpuAckN), .ctrlDsN(ctrlDsN), .strobe(strobe)
  );

  bridge_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rst(rst), .strobe(strobe),
    .cpuDataIn(cpuDataIn), .ctrlData(ctrlData)
  );
endmodule

// File: rtl/ack_bridge_checker.sv
module ack_bridge_checker #(
  parameter int DATA_W    = 8,
  parameter int ACK_DELAY = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              cpuDsN,
  input logic              cpuRdWrN,
  input logic              ctrlRdActive,
  input logic              cpuAckN,
  input logic [DATA_W-1:0] ctrlData
);
  logic [15:0] activeEdges;

  always_ff @(posedge clk) begin
    if (rst || cpuDsN || cpuRdWrN) activeEdges <= '0;
    else if (activeEdges != 16'hFFFF) activeEdges <= activeEdges + 16'd1;
  end

  assert_reset_quiet_R1: assert property (@(posedge clk) rst |=> cpuAckN);

  assert_min_latency_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(cpuAckN) |-> (activeEdges >= 16'(ACK_DELAY + 2)));

  assert_no_read_ack_R4: assert property (@(posedge clk) disable iff (rst)
    (cpuRdWrN && !cpuDsN) |=> cpuAckN);

  assert_release_R5: assert property (@(posedge clk) disable iff (rst)
    cpuDsN |=> cpuAckN);

  assert_ack_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (!cpuAckN && !cpuDsN && !cpuRdWrN) |=> !cpuAckN);

  assert_data_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (cpuDsN && $past(cpuDsN) && !ctrlRdActive && !$past(ctrlRdActive)
     && !$past(rst)) |-> $stable(ctrlData));
endmodule

bind ack_delay_bridge ack_bridge_checker #(
  .DATA_W(DATA_W), .ACK_DELAY(ACK_DELAY)
) u_chk (
  .clk(clk), .rst(rst), .cpuDsN(cpuDsN), .cpuRdWrN(cpuRdWrN),
  .ctrlRdActive(ctrlRdActive), .cpuAckN(cpuAckN), .ctrlData(ctrlData)
);

// File: tb/sim_ack_delay_bridge.sv
`timescale 1ns/1ps
module sim_ack_delay_bridge;
  localparam int DW = 8;
  localparam int D  = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cpuDsN = 1'b1;
  logic          cpuRdWrN = 1'b1;
  logic [DW-1:0] cpuDataIn = '0;
  logic          ctrlAckN = 1'b1;
  logic          ctrlRdActive = 1'b0;
  wire           cpuAckN;
  wire           ctrlDsN;
  wire  [DW-1:0] ctrlData;

  int errors = 0;
  int checks = 0;
  logic [DW-1:0] heldVal = '0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  ack_delay_bridge #(.DATA_W(DW), .ACK_DELAY(D), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst(rst), .cpuDsN(cpuDsN), .cpuRdWrN(cpuRdWrN),
    .cpuDataIn(cpuDataIn), .ctrlAckN(ctrlAckN), .ctrlRdActive(ctrlRdActive),
    .cpuAckN(cpuAckN), .ctrlDsN(ctrlDsN), .ctrlData(ctrlData)
  );

  // sampling points (negedges) from the acknowledge drive to cpuAckN low
  function automatic int expLatency();
    return D + 3;
  endfunction

  function automatic logic [DW-1:0] expFloat();
    return {DW{1'bz}};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // Called at a negedge; returns at a negedge one clock after the strobe release.
  task automatic doWrite(input logic [DW-1:0] val, input int ackWait, input int extra);
    int cnt;
    cpuDsN = 1'b0; cpuRdWrN = 1'b0; cpuDataIn = val;
    #1;
    chk(ctrlDsN == 1'b0, "R2", "ctrlDsN on write", ctrlDsN, 0);
    chk(ctrlData === val, "R7", "pass-through data", ctrlData, val);
    if (ackWait == 0) ctrlAckN = 1'b0;
    for (int i = 0; i < ackWait; i++) @(negedge clk);
    ctrlAckN = 1'b0;
    cnt = 0;
    do begin
      @(negedge clk);
      cnt++;
    end while (cpuAckN && cnt < expLatency() + 10);
    chk(cnt == expLatency(), "R3", "ack latency", cnt, expLatency());
    for (int i = 0; i < extra; i++) begin
      @(negedge clk);
      chk(cpuAckN == 1'b0, "R6", "ack held", cpuAckN, 0);
    end
    @(negedge clk);
    cpuDsN = 1'b1; ctrlAckN = 1'b1; cpuDataIn = ~val;
    heldVal = val;
    #1;
    chk(ctrlDsN == 1'b1, "R2", "ctrlDsN after release", ctrlDsN, 1);
    @(negedge clk);
    chk(cpuAckN == 1'b1, "R5", "ack released", cpuAckN, 1);
    chk(ctrlData === heldVal, "R8", "held data", ctrlData, heldVal);
  endtask

  task automatic doRead(input int len);
    cpuDsN = 1'b0; cpuRdWrN = 1'b1; cpuDataIn = DW'($urandom);
    @(negedge clk);
    ctrlAckN = 1'b0;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      chk(cpuAckN == 1'b1, "R4", "no ack on read", cpuAckN, 1);
      chk(ctrlDsN == 1'b1, "R2", "ctrlDsN on read", ctrlDsN, 1);
    end
    chk(ctrlData === heldVal, "R8", "held across read", ctrlData, heldVal);
    cpuDsN = 1'b1; ctrlAckN = 1'b1;
    @(negedge clk);
  endtask

  task automatic doAbort(input logic [DW-1:0] val);
    cpuDsN = 1'b0; cpuRdWrN = 1'b0; cpuDataIn = val; ctrlAckN = 1'b0;
    for (int i = 0; i < expLatency() - 1; i++) @(negedge clk);
    chk(cpuAckN == 1'b1, "R10", "no ack before expiry", cpuAckN, 1);
    cpuDsN = 1'b1; ctrlAckN = 1'b1; heldVal = val;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(cpuAckN == 1'b1, "R10", "aborted cycle quiet", cpuAckN, 1);
    end
  endtask

  initial begin
    for (int i = 0; i < 200000; i++) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      finish();
    end
  end

  initial begin
    void'($urandom(32'h00C0FFEE));
    repeat (3) @(negedge clk);
    chk(cpuAckN == 1'b1, "R1", "ack in reset", cpuAckN, 1);
    chk(ctrlDsN == 1'b1, "R1", "ctrlDsN in reset", ctrlDsN, 1);
    chk(ctrlData === expFloat(), "R1", "data float in reset", ctrlData, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(cpuAckN == 1'b1, "R1", "ack after reset", cpuAckN, 1);

    // idle acknowledge must not leak
    ctrlAckN = 1'b0;
    repeat (6) @(negedge clk);
    chk(cpuAckN == 1'b1, "R4", "no ack while idle", cpuAckN, 1);
    ctrlAckN = 1'b1;
    repeat (3) @(negedge clk);

    // directed: back-to-back writes with immediate acknowledge (R5 stale level)
    doWrite(8'hA5, 0, 2);
    doWrite(8'h3C, 0, 0);
    doWrite(8'h81, 3, 1);

    // tri-state during controller read
    ctrlRdActive = 1'b1; #1;
    chk(ctrlData === expFloat(), "R9", "float on ctrl read", ctrlData, 0);
    @(negedge clk);
    ctrlRdActive = 1'b0; #1;
    chk(ctrlData === heldVal, "R9", "held value returns", ctrlData, heldVal);
    @(negedge clk);

    // abort then full-latency write
    doAbort(8'h5A);
    doWrite(8'h77, 0, 0);

    // random mix
    for (int n = 0; n < 60; n++) begin
      int kind = int'($urandom_range(0, 9));
      if (kind < 6) doWrite(DW'($urandom), int'($urandom_range(0, 5)), int'($urandom_range(0, 3)));
      else if (kind < 8) doRead(int'($urandom_range(2, D + 6)));
      else if (kind < 9) doAbort(DW'($urandom));
      else begin
        ctrlRdActive = 1'b1; #1;
        chk(ctrlData === expFloat(), "R9", "random float", ctrlData, 0);
        @(negedge clk);
        ctrlRdActive = 1'b0; #1;
        chk(ctrlData === heldVal, "R9", "random restore", ctrlData, heldVal);
        @(negedge clk);
      end
      for (int k = 0; k < int'($urandom_range(0, 2)); k++) @(negedge clk);
    end
    finish();
  end
endmodule